// File: doc/BRIEF.md
# Register-Cleared Eight-Point Interrupt Controller

This block collects interrupt conditions from eight input points of a bus slave and presents them to the system bus as a single interrupt request at a programmable level. Each point has its own active-level setting, mask bit and 8-bit vector. A point's active condition is caught in a sticky input flag even when the point is masked, so software can poll masked points. The pending view is that flag ANDed with the mask. The request is raised when a pending point exists, the global enable input is high and the programmed level is non-zero.

The request is released only when software writes a clear through the register port, and that clear succeeds only once the input has gone back to its idle level. During an acknowledge cycle the block compares the acknowledged level with its own. On a match it returns the vector of the point that won the request, together with a transfer acknowledge. If the levels differ, or if the block is not requesting, it passes the acknowledge down the chain. The first point to become pending wins. The winner is held until it is cleared, so the returned vector cannot change while software services the interrupt. Raw inputs pass through a two-stage synchronizer before the level check.

Top module: `ror_irq_ctl`

## Requirements
- R1: After reset the enable, polarity and level registers and every vector read 0, the input-flag and pending registers read 0, and no request is raised. The synchronizer starts at the idle-high level, so a flag comes back only if the input is really active.
- R2: A polarity bit of 1 makes a high input level active for that point; 0 makes a low level active.
- R3: The input-flag register (byte 0x82, read only, bit i = point i) sets bit i while point i is active, whether or not point i is enabled.
- R4: The pending register (byte 0x80, bit i = point i) reads flag AND enable (enable at byte 0x83). irq_req is 1 only when a pending point exists and the level register (byte 0x84, bits 2..0) is non-zero. irq_lvl shows that level.
- R5: Writing 1 to bit i of byte 0x80 clears flag i, and with it pending bit i, only if point i is inactive at that time. Otherwise the flag stays set.
- R6: Once raised, irq_req stays high until the winning point's pending bit is cleared by a register write. If another point is then pending, irq_req is raised again for it.
- R7: irq_req is 0 whenever glb_en is 0.
- R8: When several points become pending in the same cycle, the highest-numbered one wins.
- R9: One clock after iack_in is sampled high, ack_dtack is 1 and ack_vec holds the winner's vector if irq_req was high and iack_lvl equalled the level. Otherwise ack_out is 1 and ack_dtack is 0.
- R10: The winner stays fixed while its pending bit is set: a point that becomes pending later does not replace it, even if it has a higher number.
- R11: Polarity is at byte 0x85. The vector of point i is at byte 0x87 + 2*i. Every other byte offset reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pt_in | input | 8 | Raw interrupt input levels, one per point |
| glb_en | input | 1 | Global interrupt enable from the status register |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset for reads and writes |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for addr (combinational) |
| irq_req | output | 1 | Interrupt request to the bus |
| irq_lvl | output | 3 | Level at which the request is raised |
| iack_in | input | 1 | Acknowledge arriving from up the daisy chain |
| iack_lvl | input | 3 | Level being acknowledged (address bits 3..1) |
| ack_dtack | output | 1 | Transfer acknowledge for a returned vector |
| ack_out | output | 1 | Acknowledge passed down the daisy chain |
| ack_vec | output | 8 | Returned vector (data bits 7..0) |

## Verification
The bench writes a clear while the input is still active and checks that the flag survives. A design that clears unconditionally would drop the request and lose the event. It releases two points in turn and checks that the request comes back with the second point's vector; a design that drops all requests on one clear would lose that one. It raises two points in the same cycle and checks that the higher number wins. It also raises a higher-numbered point after a lower one is already pending, and checks that the returned vector still belongs to the first. Polarity inversion, a masked point showing only in the flag register, level 0, the global enable gate and level-mismatched acknowledges that must pass down the chain are each checked at the ports.

// File: rtl/ror_pkg.sv
// Shared sizes and register byte offsets for the register-cleared interrupt controller.
package ror_pkg;
    localparam int NPT  = 8;   // interrupt points
    localparam int VW   = 8;   // register and vector width
    localparam int AW   = 8;   // register byte offset width
    localparam int LW   = 3;   // bus interrupt level width

    localparam logic [AW-1:0] OFF_PEND = 8'h80;
    localparam logic [AW-1:0] OFF_FLAG = 8'h82;
    localparam logic [AW-1:0] OFF_EN   = 8'h83;
    localparam logic [AW-1:0] OFF_LVL  = 8'h84;
    localparam logic [AW-1:0] OFF_POL  = 8'h85;
    localparam logic [AW-1:0] OFF_VEC0 = 8'h87;
    localparam int            VEC_STEP = 2;
endpackage

// File: rtl/ror_sync.sv
// Two-stage synchronizer for the raw point levels.
// Assumes: inputs are asynchronous levels. Reset loads IDLE, the level that is
// inactive under the reset polarity, so no false flag appears after reset.
module ror_sync #(
    parameter int         W    = 8,
    parameter logic [W-1:0] IDLE = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1, s2;

    // shift the raw levels through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= IDLE;
            s2 <= IDLE;
        end else begin
            s1 <= d;
            s2 <= s1;
        end
    end

    assign q = s2;
endmodule

// File: rtl/ror_flags.sv
// Sticky input flags: set while a point is active; a clear request removes a
// flag only if the point is inactive in that cycle.
// Assumes: lvl is already synchronized; pol bit 1 means active high.
module ror_flags #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] pol,
    input  logic         clr_stb,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] active,
    output logic [N-1:0] flag_q
);
    logic [N-1:0] kill, flag_d;

    // active when the level equals the polarity bit
    assign active = ~(lvl ^ pol);

    // next flags: set by activity, cleared only where inactive and requested
    always_comb begin
        kill   = clr_stb ? (clr_mask & ~active) : '0;
        flag_d = (flag_q & ~kill) | active;
    end

    // flag storage
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    // R3
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active != '0) |=> ((flag_q & $past(active)) == $past(active)));

    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & active) != '0) |=> ((flag_q & $past(flag_q & active)) == $past(flag_q & active)));
endmodule

// File: rtl/ror_arb.sv
// Winner latch: picks the highest pending point when idle and holds it until
// that point's pending bit clears, then drops for one cycle before re-arbitrating.
// Assumes: pend is the masked flag vector; N >= 2.
module ror_arb #(
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  pend,
    output logic          win_vld,
    output logic [IW-1:0] win_idx
);
    logic [IW-1:0] top_idx;
    logic          any_pend;
    logic          win_pend;

    // highest-numbered pending point
    always_comb begin
        top_idx = '0;
        for (int i = 0; i < N; i++)
            if (pend[i]) top_idx = IW'(i);
    end

    assign any_pend = |pend;
    assign win_pend = pend[win_idx];

    // latch or release the winner
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_vld <= 1'b0;
            win_idx <= '0;
        end else if (win_vld) begin
            if (!win_pend) win_vld <= 1'b0;
        end else if (any_pend) begin
            win_vld <= 1'b1;
            win_idx <= top_idx;
        end
    end

    // R10
    win_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_vld && $past(win_vld)) |-> $stable(win_idx));

    // R6
    win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_vld && win_pend) |=> win_vld);

    // R8
    win_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_vld) |-> ((($past(pend) >> win_idx) >> 1) == '0));
endmodule

// File: rtl/ror_irq_ctl.sv
// Register-cleared eight-point interrupt controller with per-point vectors and
// daisy-chained acknowledge.
// Assumes: one register access per cycle; reads are combinational on addr;
// N_PTS <= VW so each point maps to one data bit.
module ror_irq_ctl
    import ror_pkg::*;
#(
    parameter int N_PTS = NPT,
    parameter int DW    = VW,
    parameter int ADW   = AW,
    parameter int LVW   = LW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_PTS-1:0] pt_in,
    input  logic             glb_en,
    input  logic             wr_en,
    input  logic [ADW-1:0]   addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             irq_req,
    output logic [LVW-1:0]   irq_lvl,
    input  logic             iack_in,
    input  logic [LVW-1:0]   iack_lvl,
    output logic             ack_dtack,
    output logic             ack_out,
    output logic [DW-1:0]    ack_vec
);
    localparam int IW = $clog2(N_PTS);

    logic [N_PTS-1:0] en_q, pol_q, lvl_s, active, flag_q, pend;
    logic [LVW-1:0]   lvl_q;
    logic [DW-1:0]    vec_q [N_PTS];
    logic             win_vld;
    logic [IW-1:0]    win_idx;
    logic             clr_stb;

    assign clr_stb = wr_en && (addr == OFF_PEND);
    assign pend    = flag_q & en_q;

    ror_sync #(.W(N_PTS), .IDLE({N_PTS{1'b1}})) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pt_in), .q(lvl_s)
    );

    ror_flags #(.N(N_PTS)) u_flags (
        .clk(clk), .rst_n(rst_n), .lvl(lvl_s), .pol(pol_q),
        .clr_stb(clr_stb), .clr_mask(wdata[N_PTS-1:0]),
        .active(active), .flag_q(flag_q)
    );

    ror_arb #(.N(N_PTS)) u_arb (
        .clk(clk), .rst_n(rst_n), .pend(pend),
        .win_vld(win_vld), .win_idx(win_idx)
    );

    // mask, polarity and level registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            pol_q <= '0;
            lvl_q <= '0;
        end else if (wr_en) begin
            if (addr == OFF_EN)  en_q  <= wdata[N_PTS-1:0];
            if (addr == OFF_POL) pol_q <= wdata[N_PTS-1:0];
            if (addr == OFF_LVL) lvl_q <= wdata[LVW-1:0];
        end
    end

    // one vector register per point at its odd byte offset
    for (genvar g = 0; g < N_PTS; g++) begin : g_vec
        localparam logic [ADW-1:0] VOFF = ADW'(int'(OFF_VEC0) + VEC_STEP * g);
        // vector storage for point g
        always_ff @(posedge clk) begin
            if (!rst_n)                        vec_q[g] <= '0;
            else if (wr_en && addr == VOFF)    vec_q[g] <= wdata;
        end
    end

    // register read mux; unmapped offsets read all ones
    always_comb begin
        rdata = '1;
        if (addr == OFF_PEND) begin
            rdata = '0; rdata[N_PTS-1:0] = pend;
        end else if (addr == OFF_FLAG) begin
            rdata = '0; rdata[N_PTS-1:0] = flag_q;
        end else if (addr == OFF_EN) begin
            rdata = '0; rdata[N_PTS-1:0] = en_q;
        end else if (addr == OFF_POL) begin
            rdata = '0; rdata[N_PTS-1:0] = pol_q;
        end else if (addr == OFF_LVL) begin
            rdata = '0; rdata[LVW-1:0] = lvl_q;
        end
        for (int i = 0; i < N_PTS; i++)
            if (addr == ADW'(int'(OFF_VEC0) + VEC_STEP * i)) rdata = vec_q[i];
    end

    // bus request and its level
    assign irq_req = win_vld && glb_en && (lvl_q != '0);
    assign irq_lvl = lvl_q;

    // acknowledge response: vector on a level match, else pass down the chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_dtack <= 1'b0;
            ack_out   <= 1'b0;
            ack_vec   <= '0;
        end else begin
            ack_dtack <= 1'b0;
            ack_out   <= 1'b0;
            ack_vec   <= '0;
            if (iack_in) begin
                if (irq_req && iack_lvl == lvl_q) begin
                    ack_dtack <= 1'b1;
                    ack_vec   <= vec_q[win_idx];
                end else begin
                    ack_out <= 1'b1;
                end
            end
        end
    end

    // R9
    ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_dtack && ack_out));

    // R9
    ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_dtack || ack_out) |-> $past(iack_in));

    // R9
    ack_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_dtack |-> ($past(iack_lvl) == $past(lvl_q)) && $past(irq_req));

    // R7
    gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> glb_en);
endmodule

// File: tb/ror_irq_ctl_test.sv
// Directed bench for the register-cleared interrupt controller.
module ror_irq_ctl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pt_in = 8'hFF;
    logic       glb_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq_req;
    logic [2:0] irq_lvl;
    logic       iack_in = 1'b0;
    logic [2:0] iack_lvl = 3'd0;
    logic       ack_dtack, ack_out;
    logic [7:0] ack_vec;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ror_irq_ctl uut (
        .clk(clk), .rst_n(rst_n), .pt_in(pt_in), .glb_en(glb_en),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_req(irq_req), .irq_lvl(irq_lvl),
        .iack_in(iack_in), .iack_lvl(iack_lvl),
        .ack_dtack(ack_dtack), .ack_out(ack_out), .ack_vec(ack_vec)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic ack_chk(input string tag, input logic [2:0] lv,
                           input logic dt, input logic po, input logic [7:0] v);
        @(negedge clk);
        iack_in = 1'b1; iack_lvl = lv;
        @(negedge clk);
        chk({tag, " dtack"}, {7'd0, ack_dtack}, {7'd0, dt});
        chk({tag, " out"},   {7'd0, ack_out},   {7'd0, po});
        if (dt) chk({tag, " vec"}, ack_vec, v);
        iack_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        tick(4);
        chk("R1 req", {7'd0, irq_req}, 8'd0);
        rd_chk("R1 pend", 8'h80, 8'h00);
        rd_chk("R1 flag", 8'h82, 8'h00);
        rd_chk("R1 en",   8'h83, 8'h00);
        rd_chk("R1 lvl",  8'h84, 8'h00);
        rd_chk("R1 pol",  8'h85, 8'h00);
        rd_chk("R1 vec0", 8'h87, 8'h00);
    endtask

    task automatic t_map;
        for (int i = 0; i < 8; i++) wr(8'(8'h87 + 2 * i), 8'(8'hA0 + i));
        rd_chk("R11 vec2", 8'h8B, 8'hA2);
        rd_chk("R11 vec7", 8'h95, 8'hA7);
        rd_chk("R11 hole", 8'h86, 8'hFF);
        rd_chk("R11 hole81", 8'h81, 8'hFF);
    endtask

    task automatic t_masked;
        pt_in[3] = 1'b0;
        tick(6);
        rd_chk("R3 flag masked", 8'h82, 8'h08);
        rd_chk("R4 pend masked", 8'h80, 8'h00);
        chk("R4 no req masked", {7'd0, irq_req}, 8'd0);
    endtask

    task automatic t_raise;
        glb_en = 1'b1;
        wr(8'h83, 8'h08);
        tick(3);
        chk("R4 lvl0 no req", {7'd0, irq_req}, 8'd0);
        wr(8'h84, 8'h05);
        tick(1);
        rd_chk("R4 pend", 8'h80, 8'h08);
        chk("R4 req", {7'd0, irq_req}, 8'd1);
        chk("R4 lvl", {5'd0, irq_lvl}, 8'd5);
        glb_en = 1'b0;
        tick(1);
        chk("R7 gated", {7'd0, irq_req}, 8'd0);
        glb_en = 1'b1;
        tick(1);
    endtask

    task automatic t_clear;
        wr(8'h80, 8'h08);
        tick(2);
        rd_chk("R5 flag kept", 8'h82, 8'h08);
        chk("R5 req kept", {7'd0, irq_req}, 8'd1);
        pt_in[3] = 1'b1;
        tick(5);
        chk("R6 req held", {7'd0, irq_req}, 8'd1);
        rd_chk("R6 flag held", 8'h82, 8'h08);
        wr(8'h80, 8'h08);
        tick(3);
        rd_chk("R5 flag cleared", 8'h82, 8'h00);
        chk("R6 req released", {7'd0, irq_req}, 8'd0);
    endtask

    task automatic t_polarity;
        wr(8'h83, 8'h00);
        wr(8'h85, 8'h40);
        pt_in[6] = 1'b0;
        tick(4);
        wr(8'h80, 8'h40);
        tick(2);
        rd_chk("R2 low inactive", 8'h82, 8'h00);
        pt_in[6] = 1'b1;
        tick(6);
        rd_chk("R2 high active", 8'h82, 8'h40);
        pt_in[6] = 1'b0;
        tick(4);
        wr(8'h80, 8'h40);
        tick(2);
    endtask

    task automatic t_simul;
        wr(8'h83, 8'h42);
        pt_in[1] = 1'b0;
        pt_in[6] = 1'b1;
        tick(6);
        chk("R8 req", {7'd0, irq_req}, 8'd1);
        ack_chk("R8 top wins", 3'd5, 1'b1, 1'b0, 8'hA6);
        pt_in[1] = 1'b1;
        pt_in[6] = 1'b0;
        tick(4);
        wr(8'h80, 8'h40);
        tick(4);
        chk("R6 re-request", {7'd0, irq_req}, 8'd1);
        ack_chk("R6 second vector", 3'd5, 1'b1, 1'b0, 8'hA1);
        wr(8'h80, 8'h02);
        tick(4);
        chk("R6 all clear", {7'd0, irq_req}, 8'd0);
    endtask

    task automatic t_chain;
        pt_in[1] = 1'b0;
        tick(6);
        ack_chk("R9 mismatch", 3'd3, 1'b0, 1'b1, 8'h00);
        wr(8'h83, 8'hC2);
        pt_in[7] = 1'b0;
        tick(6);
        ack_chk("R10 first stays", 3'd5, 1'b1, 1'b0, 8'hA1);
        pt_in[1] = 1'b1;
        pt_in[7] = 1'b1;
        tick(4);
        wr(8'h80, 8'h02);
        tick(4);
        ack_chk("R10 later point next", 3'd5, 1'b1, 1'b0, 8'hA7);
        wr(8'h80, 8'h80);
        tick(4);
        chk("R6 idle", {7'd0, irq_req}, 8'd0);
        ack_chk("R9 no request passes", 3'd5, 1'b0, 1'b1, 8'h00);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_masked();
        t_raise();
        t_clear();
        t_polarity();
        t_simul();
        t_chain();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule